// File: doc/BRIEF.md
# Multi-Mode CRC Engine

This block is a register-mapped CRC calculator. Software picks one of four CRC
modes (a 16-bit CCITT variant, an 8-bit, a 16-bit and a 32-bit CRC), loads a
seed, and then writes data words of 8, 16 or 32 bits. Each accepted word is
folded into a running CRC state one bit per clock, most significant bit first.
The generator polynomial lives in a writable register that is preloaded with
the mode's usual value whenever the mode changes. Optional attributes
complement or bit-reverse the written data before it is folded in, and
bit-reverse or complement the checksum on the way out. The checksum read-out
is cut down to the width of the active mode.

The engine is a two-state machine. IDLE holds the state. From IDLE, a pending
seed reload copies the seed into the state and stays in IDLE. An accepted data
write with the engine enabled takes the transition IDLE to SHIFT and loads the
transformed word. SHIFT to SHIFT repeats while bits remain. SHIFT to IDLE
follows the last bit. While the engine is in SHIFT, or while a seed reload is
pending, every bus write is stalled by dropping `bus_ready`. Reads are never
stalled and are answered in the same cycle.

Register map (word address on `bus_addr`): 0 control, 1 seed, 2 polynomial,
3 data (write only), 4 checksum (read only). Other addresses read as zero.
Control bits: [0] enable, [1] seed reload (self-clearing), [3:2] mode
(0 CCITT, 1 CRC-8, 2 CRC-16, 3 CRC-32), [5:4] write width (0 = 8, 1 = 16,
2 or 3 = 32 bits), [6] reverse data, [7] complement data, [8] reverse
checksum, [9] complement checksum, [10] busy (read only).

Top module: `crc_engine`

## Requirements
- R1: After reset the control register reads 0, the polynomial register reads 0x1021, the seed register reads 0 and the checksum reads 0.
- R2: A control write whose mode field [3:2] differs from the current mode loads that mode's default polynomial (CCITT 0x1021, CRC-8 0x07, CRC-16 0x8005, CRC-32 0x04C11DB7). A later polynomial write replaces that value.
- R3: Writing control with bit 1 set makes bit 1 read 1 in the cycle after the write and 0 one cycle later. At that second edge the running state becomes the seed masked to the mode width, so the checksum then reads the seed's low 8, 16 or 32 bits.
- R4: A data write consumes the low 8, 16 or 32 bits of the word, as set by control [5:4]. It folds them MSB first into the state with new = ((state << 1) XOR (polynomial if (data bit XOR state MSB))), kept within the mode width.
- R5: Control bit 6 reverses the bit order of the consumed data within the write width. Control bit 7 inverts the consumed bits. The two may be combined.
- R6: Control bit 8 reverses the checksum within the mode width. Control bit 9 then inverts it within the mode width.
- R7: The checksum read is masked to 8 bits for CRC-8, to 16 bits for CCITT and CRC-16, and is the full 32 bits for CRC-32.
- R8: With control bit 0 clear, a data write is accepted but leaves the checksum unchanged and does not set busy.
- R9: Busy (control bit 10) reads 1 for exactly as many cycles as the write width after an enabled data write. While busy, `bus_ready` is 0 for writes and 1 for reads.
- R10: In CRC-8 mode only the low 8 bits of the polynomial register are used, with the x^8 term implied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted this cycle. Low for writes while busy or while a seed reload is pending |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read request |

## Verification
The folding function is checked against well-known check values of the ASCII
string "123456789". The 32-bit reflected CRC with all attributes on separates
the data-reversal and output-transform paths. The 16-bit CCITT run with no
attributes and the 8-bit run isolate the plain MSB-first shift and the implied
top bit of the narrow mode. Seeded random runs then mix modes, polynomials,
seeds, write widths and all attribute combinations over several words each, so
errors in how the width is masked or how a word is aligned show up as checksum
mismatches. Directed cases count the busy cycles for a 16-bit write, probe
write stalling and the one-cycle seed-reload flag, and confirm that a write
with the engine disabled leaves the checksum untouched.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int XLEN = 32;
    localparam int CNT_W = $clog2(XLEN) + 1;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_SEED = 3'd1;
    localparam logic [2:0] ADR_POLY = 3'd2;
    localparam logic [2:0] ADR_DATA = 3'd3;
    localparam logic [2:0] ADR_SUM  = 3'd4;

    typedef enum logic [1:0] {
        MODE_CCITT = 2'd0,
        MODE_C8    = 2'd1,
        MODE_C16   = 2'd2,
        MODE_C32   = 2'd3
    } crc_mode_e;

    typedef struct packed {
        logic      sum_cmp;   // bit 9
        logic      sum_rev;   // bit 8
        logic      din_cmp;   // bit 7
        logic      din_rev;   // bit 6
        logic [1:0] wlen;     // bits 5:4
        crc_mode_e mode;      // bits 3:2
        logic      init;      // bit 1
        logic      en;        // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [CNT_W-1:0] mode_width(input crc_mode_e m);
        unique case (m)
            MODE_C8:  return CNT_W'(8);
            MODE_C32: return CNT_W'(32);
            default:  return CNT_W'(16);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] wlen_width(input logic [1:0] wl);
        unique case (wl)
            2'd0:    return CNT_W'(8);
            2'd1:    return CNT_W'(16);
            default: return CNT_W'(32);
        endcase
    endfunction

    function automatic logic [XLEN-1:0] width_mask(input logic [CNT_W-1:0] n);
        logic [2*XLEN-1:0] wide;
        wide = ({{(2*XLEN-1){1'b0}}, 1'b1} << n) - 1'b1;
        return wide[XLEN-1:0];
    endfunction

    function automatic logic [XLEN-1:0] default_poly(input crc_mode_e m);
        unique case (m)
            MODE_C8:  return 32'h0000_0007;
            MODE_C16: return 32'h0000_8005;
            MODE_C32: return 32'h04C1_1DB7;
            default:  return 32'h0000_1021;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] rev_within(input logic [XLEN-1:0] x,
                                                  input logic [CNT_W-1:0] n);
        logic [XLEN-1:0] r;
        r = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (i < int'(n)) r[i] = x[int'(n) - 1 - i];
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_regs.sv
module crc_regs
    import crc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [XLEN-1:0]   wr_data,
    output ctrl_t             ctrl_q,
    output logic [XLEN-1:0]   seed_q,
    output logic [XLEN-1:0]   poly_q
);

    ctrl_t ctrl_new;
    assign ctrl_new = ctrl_t'(wr_data[CTRL_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            seed_q <= '0;
            poly_q <= default_poly(MODE_CCITT);
        end else begin
            ctrl_q.init <= 1'b0;
            if (wr_en) begin
                if (wr_addr == ADDR_W'(ADR_CTRL)) begin
                    ctrl_q <= ctrl_new;
                    if (ctrl_new.mode != ctrl_q.mode)
                        poly_q <= default_poly(ctrl_new.mode);
                end else if (wr_addr == ADDR_W'(ADR_SEED)) begin
                    seed_q <= wr_data;
                end else if (wr_addr == ADDR_W'(ADR_POLY)) begin
                    poly_q <= wr_data;
                end
            end
        end
    end

    // Writes are stalled while a reload is pending, so the flag lasts one cycle
    AST_INIT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.init |=> !ctrl_q.init); // R3

endmodule

// File: rtl/crc_shifter.sv
module crc_shifter
    import crc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            seed_load,
    input  logic [XLEN-1:0] seed,
    input  logic [XLEN-1:0] poly,
    input  crc_mode_e       mode,
    input  logic [1:0]      wlen,
    input  logic            din_rev,
    input  logic            din_cmp,
    input  logic [XLEN-1:0] wdata,
    output logic            busy,
    output logic [XLEN-1:0] crc_state
);

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } shift_state_e;

    shift_state_e state_q, state_d;

    logic [XLEN-1:0]  crc_q, sh_q;
    logic [CNT_W-1:0] cnt_q;

    logic [CNT_W-1:0] n_w, d_w;
    logic [XLEN-1:0]  n_mask, d_mask;
    logic [XLEN-1:0]  din_masked, din_turned, din_final, din_aligned;
    logic             fb;
    logic [XLEN-1:0]  crc_step;

    assign n_w    = mode_width(mode);
    assign d_w    = wlen_width(wlen);
    assign n_mask = width_mask(n_w);
    assign d_mask = width_mask(d_w);

    // Input transform on the whole consumed word, then MSB alignment
    assign din_masked  = wdata & d_mask;
    assign din_turned  = din_rev ? rev_within(din_masked, d_w) : din_masked;
    assign din_final   = din_cmp ? (din_turned ^ d_mask) : din_turned;
    assign din_aligned = din_final << (CNT_W'(XLEN) - d_w);

    assign fb       = sh_q[XLEN-1] ^ crc_q[n_w - 1'b1];
    assign crc_step = ((crc_q << 1) ^ (fb ? poly : '0)) & n_mask;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SHIFT;
            ST_SHIFT: if (cnt_q == CNT_W'(1)) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath driven by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
            sh_q  <= '0;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (seed_load) begin
                        crc_q <= seed & n_mask;
                    end else if (start) begin
                        sh_q  <= din_aligned;
                        cnt_q <= d_w;
                    end
                end
                ST_SHIFT: begin
                    crc_q <= crc_step;
                    sh_q  <= sh_q << 1;
                    cnt_q <= cnt_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy      = (state_q == ST_SHIFT);
    assign crc_state = crc_q;

    AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start, seed_load})); // R3

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !seed_load) |=> $stable(crc_q)); // R8

endmodule

// File: rtl/crc_out.sv
module crc_out
    import crc_pkg::*;
(
    input  logic [XLEN-1:0] crc_state,
    input  crc_mode_e       mode,
    input  logic            sum_rev,
    input  logic            sum_cmp,
    output logic [XLEN-1:0] checksum
);

    logic [CNT_W-1:0] n_w;
    logic [XLEN-1:0]  n_mask, base, turned;

    assign n_w    = mode_width(mode);
    assign n_mask = width_mask(n_w);
    assign base   = crc_state & n_mask;
    assign turned = sum_rev ? rev_within(base, n_w) : base;
    assign checksum = sum_cmp ? (turned ^ n_mask) : turned;

endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [XLEN-1:0]   bus_wdata,
    output logic              bus_ready,
    output logic [XLEN-1:0]   bus_rdata
);

    ctrl_t           ctrl_q;
    logic [XLEN-1:0] seed_q, poly_q, crc_state, checksum;
    logic            busy, wr_acc, start;

    assign bus_ready = !bus_write || !(busy || ctrl_q.init);
    assign wr_acc    = bus_valid && bus_write && bus_ready;
    assign start     = wr_acc && (bus_addr == ADDR_W'(ADR_DATA)) && ctrl_q.en;

    crc_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_acc),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .ctrl_q  (ctrl_q),
        .seed_q  (seed_q),
        .poly_q  (poly_q)
    );

    crc_shifter shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .seed_load (ctrl_q.init),
        .seed      (seed_q),
        .poly      (poly_q),
        .mode      (ctrl_q.mode),
        .wlen      (ctrl_q.wlen),
        .din_rev   (ctrl_q.din_rev),
        .din_cmp   (ctrl_q.din_cmp),
        .wdata     (bus_wdata),
        .busy      (busy),
        .crc_state (crc_state)
    );

    crc_out out_i (
        .crc_state (crc_state),
        .mode      (ctrl_q.mode),
        .sum_rev   (ctrl_q.sum_rev),
        .sum_cmp   (ctrl_q.sum_cmp),
        .checksum  (checksum)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            if (bus_addr == ADDR_W'(ADR_CTRL))
                bus_rdata = {{(XLEN-CTRL_W-1){1'b0}}, busy, ctrl_q};
            else if (bus_addr == ADDR_W'(ADR_SEED))
                bus_rdata = seed_q;
            else if (bus_addr == ADDR_W'(ADR_POLY))
                bus_rdata = poly_q;
            else if (bus_addr == ADDR_W'(ADR_SUM))
                bus_rdata = checksum;
        end
    end

    AST_NO_WRITE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_valid && bus_write) |-> !bus_ready); // R9

    AST_CFG_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(poly_q) && $stable(ctrl_q.mode))); // R9

endmodule

// File: tb/crc_engine_tb_top.sv
module crc_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    crc_engine dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG && !done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        while (!bus_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        int n = 0;
        do begin
            rd(3'd0, c);
            n++;
        end while (c[10] && n < 100);
    endtask

    function automatic logic [31:0] msk(input int n);
        logic [63:0] w;
        w = (64'd1 << n) - 64'd1;
        return w[31:0];
    endfunction

    function automatic int mwidth(input int m);
        return (m == 1) ? 8 : (m == 3) ? 32 : 16;
    endfunction

    function automatic int wwidth(input int wl);
        return (wl == 0) ? 8 : (wl == 1) ? 16 : 32;
    endfunction

    function automatic logic [31:0] dpoly(input int m);
        case (m)
            1: return 32'h07;
            2: return 32'h8005;
            3: return 32'h04C11DB7;
            default: return 32'h1021;
        endcase
    endfunction

    function automatic logic [31:0] ref_step(input logic [31:0] crc, input logic [31:0] poly,
                                             input int n, input int w, input logic [31:0] word,
                                             input bit rv, input bit cp);
        logic [31:0] x, y, nm, wm;
        bit fb;
        nm = msk(n); wm = msk(w);
        x = word & wm;
        if (rv) begin
            y = '0;
            for (int i = 0; i < w; i++) y[i] = x[w-1-i];
            x = y;
        end
        if (cp) x = x ^ wm;
        for (int i = w - 1; i >= 0; i--) begin
            fb = x[i] ^ crc[n-1];
            crc = (crc << 1) & nm;
            if (fb) crc = crc ^ (poly & nm);
        end
        return crc;
    endfunction

    function automatic logic [31:0] ref_out(input logic [31:0] crc, input int n,
                                            input bit rv, input bit cp);
        logic [31:0] r, y;
        r = crc & msk(n);
        if (rv) begin
            y = '0;
            for (int i = 0; i < n; i++) y[i] = r[n-1-i];
            r = y;
        end
        if (cp) r = r ^ msk(n);
        return r;
    endfunction

    function automatic logic [31:0] ctl(input bit en, input bit init, input int m, input int wl,
                                        input bit dr, input bit dc, input bit sr, input bit sc);
        return {22'd0, sc, sr, dc, dr, wl[1:0], m[1:0], init, en};
    endfunction

    task automatic run_string(input int m, input logic [31:0] seed, input bit dr,
                              input bit sr, input bit sc, input logic [31:0] exp,
                              input string req);
        logic [31:0] v;
        wr(3'd0, ctl(0, 0, (m + 1) % 4, 0, 0, 0, 0, 0));
        wr(3'd0, ctl(0, 0, m, 0, 0, 0, 0, 0));
        wr(3'd1, seed);
        wr(3'd0, ctl(1, 1, m, 0, dr, 0, sr, sc));
        for (int k = 0; k < 9; k++) begin
            wr(3'd3, 32'h31 + k);
            wait_idle();
        end
        rd(3'd4, v);
        chk(req, v, exp);
    endtask

    initial begin
        logic [31:0] v, crc, poly, seed, word;
        int m, wl, n, w, nwords, cnt;
        bit dr, dc, sr, sc;
        v = $urandom(32'h5EED_1234);

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(3'd2, v); chk("R1 poly", v, 32'h1021);
        rd(3'd1, v); chk("R1 seed", v, 32'h0);
        rd(3'd4, v); chk("R1 sum", v, 32'h0);

        // R2 default polynomial per mode, then overwrite
        for (int mm = 1; mm < 5; mm++) begin
            wr(3'd0, ctl(0, 0, mm % 4, 0, 0, 0, 0, 0));
            rd(3'd2, v); chk("R2 default poly", v, dpoly(mm % 4));
        end
        wr(3'd2, 32'h0000_ABCD);
        rd(3'd2, v); chk("R2 poly write", v, 32'h0000_ABCD);

        // R3 seed reload flag and value; R7 masking of seed readback
        wr(3'd0, ctl(0, 0, 1, 0, 0, 0, 0, 0));
        wr(3'd1, 32'hDEAD_BEEF);
        wr(3'd0, ctl(0, 1, 1, 0, 0, 0, 0, 0));
        rd(3'd0, v); chk("R3 init flag set", {31'd0, v[1]}, 32'd1);
        rd(3'd0, v); chk("R3 init flag cleared", {31'd0, v[1]}, 32'd0);
        rd(3'd4, v); chk("R3 R7 seed crc8", v, 32'hEF);
        wr(3'd0, ctl(0, 1, 3, 0, 0, 0, 0, 0));
        wait_idle();
        rd(3'd4, v); chk("R3 R7 seed crc32", v, 32'hDEAD_BEEF);
        wr(3'd0, ctl(0, 1, 2, 0, 0, 0, 0, 0));
        wait_idle();
        rd(3'd4, v); chk("R3 R7 seed crc16", v, 32'hBEEF);

        // R8 disabled engine ignores data
        wr(3'd3, 32'h1234_5678);
        rd(3'd0, v); chk("R8 no busy", {31'd0, v[10]}, 32'd0);
        rd(3'd4, v); chk("R8 sum unchanged", v, 32'hBEEF);

        // R9 busy length and stall for a 16-bit write
        wr(3'd0, ctl(1, 0, 2, 1, 0, 0, 0, 0));
        wr(3'd3, 32'h0000_A5A5);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'd4;
        #1 chk("R9 write stalled", {31'd0, bus_ready}, 32'd0);
        bus_write = 1'b0;
        #1 chk("R9 read ready", {31'd0, bus_ready}, 32'd1);
        bus_valid = 1'b0;
        cnt = 1;
        for (int k = 0; k < 40; k++) begin
            rd(3'd0, v);
            if (v[10]) cnt++;
            else break;
        end
        chk("R9 busy cycles", cnt, 16);
        rd(3'd4, v);
        chk("R4 16-bit word", v, ref_step(32'hBEEF, 32'h8005, 16, 16, 32'hA5A5, 0, 0));

        // R4 R5 R6 known check values
        run_string(3, 32'hFFFF_FFFF, 1, 1, 1, 32'hCBF4_3926, "R5 R6 crc32 reflected");
        run_string(0, 32'h0000_FFFF, 0, 0, 0, 32'h0000_29B1, "R4 ccitt");
        run_string(1, 32'h0, 0, 0, 0, 32'h0000_00F4, "R10 crc8");

        // R10 upper polynomial bits ignored in CRC-8 mode
        wr(3'd0, ctl(0, 0, 1, 0, 0, 0, 0, 0));
        wr(3'd2, 32'hFFFF_FF07);
        wr(3'd1, 32'h0);
        wr(3'd0, ctl(1, 1, 1, 0, 0, 0, 0, 0));
        wr(3'd3, 32'h5A);
        wait_idle();
        rd(3'd4, v);
        chk("R10 poly high bits", v, ref_step(0, 32'h07, 8, 8, 32'h5A, 0, 0));

        // Constrained random: R4 R5 R6 R7
        for (int it = 0; it < 40; it++) begin
            m = int'($urandom % 4);
            wl = int'($urandom % 4);
            dr = $urandom % 2; dc = $urandom % 2;
            sr = $urandom % 2; sc = $urandom % 2;
            n = mwidth(m); w = wwidth(wl);
            wr(3'd0, ctl(0, 0, (m + 1) % 4, 0, 0, 0, 0, 0));
            wr(3'd0, ctl(0, 0, m, 0, 0, 0, 0, 0));
            poly = dpoly(m);
            if ($urandom % 2) begin
                poly = $urandom | 32'h1;
                wr(3'd2, poly);
            end
            seed = $urandom;
            wr(3'd1, seed);
            wr(3'd0, ctl(1, 1, m, wl, dr, dc, sr, sc));
            crc = seed & msk(n);
            nwords = 1 + int'($urandom % 4);
            for (int k = 0; k < nwords; k++) begin
                word = $urandom;
                wr(3'd3, word);
                wait_idle();
                crc = ref_step(crc, poly, n, w, word, dr, dc);
            end
            rd(3'd4, v);
            chk("R4 R5 R6 R7 random", v, ref_out(crc, n, sr, sc));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule